// File: doc/BRIEF.md
# Programmable Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio N = P·M + S. The base modulus M is fixed when the block is built, and P and S are program inputs. The division is not done by a single modulo-N counter. A dual-modulus prescaler divides the input clock by M or by M+1. Two down-counters clocked by the prescaler's terminal event steer it: a program counter that sets the number of prescaler cycles in each output period, and a swallow counter that sets how many of those cycles use the longer modulus.

The block samples the program inputs only when an output period begins, so software or a channel-select controller can change them at any time without disturbing the period in progress. A setting with S greater than P, or with P equal to zero, cannot be realised. The block flags it and keeps dividing by the last legal ratio. Each output period produces one registered pulse, one input clock wide. For M = 4 the prescaler is a three-flip-flop 4/5 cell. Any other M of at least 2 uses a counter-based prescaler.

Top module: `pswl_divider`

## Requirements
- R1: The number of input clock cycles from one div_out pulse to the next equals P·M + S, where P and S are the values latched at the start of that period. M defaults to 4.
- R2: div_out is driven by a register and is high for exactly one input clock cycle per output period.
- R3: The prescaler's cycle lasts M+1 input clocks while modulus control is high and M input clocks while it is low.
- R4: In each output period the first S prescaler cycles run at M+1 and the remaining P−S run at M. With S = 0 the ratio is P·M. With S = P it is P·(M+1).
- R5: prog_p and prog_s are sampled only at the edge that starts an output period. A change during a period does not alter the length of that period.
- R6: If prog_s > prog_p or prog_p = 0 when a period starts, cfg_err goes high with that period's pulse and the period uses the last legal P and S.
- R7: cfg_err returns low at the first period start that samples a legal setting, and that setting takes effect.
- R8: While rst is high, div_out and cfg_err are low.
- R9: If the first setting sampled after reset is illegal, the block divides by M (P = 1, S = 0) and raises cfg_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| prog_p | input | PW | Program count P (prescaler cycles per output period) |
| prog_s | input | PW | Swallow count S (cycles at M+1), must not exceed P |
| div_out | output | 1 | Divided output, one-cycle pulse per period |
| cfg_err | output | 1 | High while the running period uses a held ratio because the sampled setting was illegal |

## Verification
The hardest case to reach is a setting change that arrives in the middle of a period. The period boundary is visible only through div_out, so the stimulus aligns itself to a pulse, waits a few clocks, and then writes a new ratio. It then checks that the old period still closes at the old length. Illegal settings are applied in the same pulse-aligned way, both during normal running and as the very first sample after reset. This shows the held ratio, the fallback to a plain divide-by-M, and the clearing of the error flag when a legal value returns.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
   // modulus control towards the dual-modulus prescaler
   typedef enum logic {
      MOD_LOW  = 1'b0,   // divide by M
      MOD_HIGH = 1'b1    // divide by M+1
   } modsel_e;
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
   import pswl_pkg::*;
#(
   parameter int M = 4
) (
   input  logic    clk_in,
   input  logic    rst,
   input  modsel_e mc,
   output logic    tc
);
   localparam int GW = $clog2(M + 2) + 1;

   generate
      if (M < 2) begin : g_bad_modulus
         $error("pswl_prescaler: M must be at least 2");
      end

      if (M == 4) begin : g_cell45
         // three-flop 4/5 cell; mc is consulted while q2 is high
         logic q1, q2, q3;
         always_ff @(posedge clk_in) begin
            if (rst) begin
               q1 <= 1'b0;
               q2 <= 1'b0;
               q3 <= 1'b0;
            end else begin
               q1 <= ~q2 & ~q3;
               q2 <= q1;
               q3 <= q2 & (mc == MOD_HIGH);
            end
         end
         assign tc = ~q1 & ~q2 & ~q3;
      end else begin : g_counter
         localparam int CW = $clog2(M + 1);
         logic [CW-1:0] cnt;
         logic          last;
         assign last = (mc == MOD_HIGH) ? (cnt == CW'(M)) : (cnt == CW'(M - 1));
         always_ff @(posedge clk_in) begin
            if (rst)       cnt <= '0;
            else if (last) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
         assign tc = (cnt == '0);
      end
   endgenerate

   // cycles elapsed since the previous terminal event
   logic [GW-1:0] gap;
   always_ff @(posedge clk_in) begin
      if (rst)     gap <= '0;
      else if (tc) gap <= GW'(1);
      else if (gap != '0) gap <= gap + 1'b1;
   end

   // R3: prescaler cycle length follows modulus control
   p_prescale_len_r3: assert property (@(posedge clk_in) disable iff (rst)
      (tc && gap != '0) |-> (gap == ((mc == MOD_HIGH) ? GW'(M + 1) : GW'(M))));

   p_tc_single_r3: assert property (@(posedge clk_in) disable iff (rst)
      tc |=> !tc);
endmodule

// File: rtl/pswl_sequencer.sv
module pswl_sequencer
   import pswl_pkg::*;
#(
   parameter int PW = 6
) (
   input  logic          clk_in,
   input  logic          rst,
   input  logic          tc,
   input  logic [PW-1:0] p_in,
   input  logic [PW-1:0] s_in,
   output modsel_e       mc,
   output logic          period_start,
   output logic          cfg_err
);
   logic [PW-1:0] prog_cnt, swal_cnt;
   logic [PW-1:0] hold_p, hold_s;
   logic [PW-1:0] use_p, use_s;
   logic          legal;

   always_comb begin
      legal = (p_in != '0) && (s_in <= p_in);
      use_p = legal ? p_in : hold_p;
      use_s = legal ? s_in : hold_s;
   end

   // program counter at its terminal value on a prescaler event ends the period
   assign period_start = tc && (prog_cnt == '0);

   always_ff @(posedge clk_in) begin
      if (rst) begin
         prog_cnt <= '0;
         swal_cnt <= '0;
         mc       <= MOD_LOW;
         hold_p   <= PW'(1);
         hold_s   <= '0;
         cfg_err  <= 1'b0;
      end else if (tc) begin
         if (prog_cnt == '0) begin
            prog_cnt <= use_p - 1'b1;
            mc       <= (use_s != '0) ? MOD_HIGH : MOD_LOW;
            swal_cnt <= (use_s != '0) ? use_s - 1'b1 : '0;
            cfg_err  <= !legal;
            if (legal) begin
               hold_p <= p_in;
               hold_s <= s_in;
            end
         end else begin
            prog_cnt <= prog_cnt - 1'b1;
            mc       <= (swal_cnt != '0) ? MOD_HIGH : MOD_LOW;
            if (swal_cnt != '0) swal_cnt <= swal_cnt - 1'b1;
         end
      end
   end

   // R4: modulus only switches at a prescaler boundary
   p_mc_stable_r4: assert property (@(posedge clk_in) disable iff (rst)
      !tc |=> $stable(mc));

   // R4: swallow cycles never outnumber the remaining program cycles
   p_swallow_within_r4: assert property (@(posedge clk_in) disable iff (rst)
      swal_cnt <= prog_cnt);

   // R6: the held ratio is always legal
   p_hold_legal_r6: assert property (@(posedge clk_in) disable iff (rst)
      (hold_p != '0) && (hold_s <= hold_p));
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider
   import pswl_pkg::*;
#(
   parameter int M  = 4,
   parameter int PW = 6
) (
   input  logic          clk_in,
   input  logic          rst,
   input  logic [PW-1:0] prog_p,
   input  logic [PW-1:0] prog_s,
   output logic          div_out,
   output logic          cfg_err
);
   generate
      if (PW < 1) begin : g_bad_width
         $error("pswl_divider: PW must be at least 1");
      end
   endgenerate

   modsel_e mc;
   logic    tc;
   logic    period_start;

   pswl_prescaler #(.M(M)) u_pre (
      .clk_in (clk_in),
      .rst    (rst),
      .mc     (mc),
      .tc     (tc)
   );

   pswl_sequencer #(.PW(PW)) u_seq (
      .clk_in       (clk_in),
      .rst          (rst),
      .tc           (tc),
      .p_in         (prog_p),
      .s_in         (prog_s),
      .mc           (mc),
      .period_start (period_start),
      .cfg_err      (cfg_err)
   );

   always_ff @(posedge clk_in) begin
      if (rst) div_out <= 1'b0;
      else     div_out <= period_start;
   end

   // R2: output pulse is a single input clock wide
   p_pulse_width_r2: assert property (@(posedge clk_in) disable iff (rst)
      div_out |=> !div_out);

   // R6: error flag only moves together with an output pulse
   p_err_at_reload_r6: assert property (@(posedge clk_in) disable iff (rst)
      !$stable(cfg_err) |-> div_out);
endmodule

// File: tb/tb_pswl_divider.sv
module tb_pswl_divider;
   localparam int CLK_PERIOD = 10;
   localparam int M  = 4;
   localparam int PW = 6;
   // {P, S, expected input cycles per output period}
   localparam int VEC [8][3] = '{
      '{1, 0, 4}, '{1, 1, 5}, '{3, 0, 12}, '{3, 3, 15},
      '{5, 2, 22}, '{2, 1, 9}, '{10, 7, 47}, '{63, 63, 315}
   };

   logic          clk_in = 1'b0;
   logic          rst    = 1'b1;
   logic [PW-1:0] prog_p = 6'd3;
   logic [PW-1:0] prog_s = 6'd1;
   logic          div_out, cfg_err;
   int            n_chk = 0, n_bad = 0;
   bit            done  = 1'b0;

   pswl_divider #(.M(M), .PW(PW)) dut (
      .clk_in (clk_in), .rst (rst), .prog_p (prog_p), .prog_s (prog_s),
      .div_out (div_out), .cfg_err (cfg_err)
   );

   always #(CLK_PERIOD/2) clk_in = ~clk_in;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // called at a negedge where div_out is high; returns cycles to the next pulse
   task automatic measure(output int n);
      n = 0;
      @(negedge clk_in); n++;
      check(div_out == 1'b0, "R2 pulse width", int'(div_out), 0);
      while (!div_out && n < 2000) begin
         @(negedge clk_in); n++;
      end
   endtask

   task automatic wait_pulse();
      for (int k = 0; k < 1000 && !div_out; k++) @(negedge clk_in);
   endtask

   task automatic set_cfg(input int p, input int s);
      prog_p = PW'(p);
      prog_s = PW'(s);
   endtask

   initial begin
      int n;
      // R8: reset state
      repeat (4) @(negedge clk_in);
      check(div_out == 1'b0, "R8 out in reset", int'(div_out), 0);
      check(cfg_err == 1'b0, "R8 err in reset", int'(cfg_err), 0);
      rst = 1'b0;
      @(negedge clk_in);
      wait_pulse();

      // R1/R3/R4: table of ratios, including S = 0 and S = P
      for (int i = 0; i < 8; i++) begin
         set_cfg(VEC[i][0], VEC[i][1]);
         measure(n);           // period already running on old setting
         measure(n);
         check(n == VEC[i][2], $sformatf("R1 R3 R4 ratio P=%0d S=%0d", VEC[i][0], VEC[i][1]),
               n, VEC[i][2]);
         check(cfg_err == 1'b0, "R7 err low for legal", int'(cfg_err), 0);
      end

      // R5: change in the middle of a period
      set_cfg(2, 1);
      measure(n);
      measure(n);
      repeat (3) @(negedge clk_in);
      set_cfg(7, 3);
      measure(n);
      check(n + 3 == 9, "R5 mid-period change ignored", n + 3, 9);
      measure(n);
      check(n == 31, "R1 ratio after change", n, 31);

      // R6: S > P holds the last legal ratio
      set_cfg(2, 3);
      measure(n);
      check(cfg_err == 1'b1, "R6 err raised S>P", int'(cfg_err), 1);
      measure(n);
      check(n == 31, "R6 held ratio S>P", n, 31);
      set_cfg(0, 0);
      measure(n);
      measure(n);
      check(n == 31, "R6 held ratio P=0", n, 31);
      check(cfg_err == 1'b1, "R6 err P=0", int'(cfg_err), 1);

      // R7: legal value clears the flag
      set_cfg(4, 4);
      measure(n);
      check(cfg_err == 1'b0, "R7 err cleared", int'(cfg_err), 0);
      measure(n);
      check(n == 20, "R7 R4 new ratio S=P", n, 20);

      // R9: illegal setting as first sample after reset
      @(negedge clk_in);
      rst = 1'b1;
      set_cfg(5, 6);
      repeat (3) @(negedge clk_in);
      check(div_out == 1'b0, "R8 out in second reset", int'(div_out), 0);
      check(cfg_err == 1'b0, "R8 err in second reset", int'(cfg_err), 0);
      rst = 1'b0;
      @(negedge clk_in);
      wait_pulse();
      check(cfg_err == 1'b1, "R9 err after reset", int'(cfg_err), 1);
      measure(n);
      check(n == M, "R9 fallback divide by M", n, M);

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk_in);
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      finish_run();
   end
endmodule